// File: doc/BRIEF.md
# PSRAM Page-Mode Controller

This block is a synchronous controller for an asynchronous pseudo-static RAM. The memory holds 4,194,304 words of 16 bits and is addressed by a 22-bit word address. The host side is a valid/ready request port. Each request carries a read/write flag, a word address, write data and one enable bit per byte lane. Read results come back on a one-cycle response strobe. On the memory side the controller drives chip-enable, output-enable, write-enable, two byte-lane selects, an active-low sleep select and a split tri-state data bus (output value, output enable, input value). All timing is met by counting clock cycles. Every wait count is derived at elaboration from the clock period and the memory's access times in picoseconds.

The controller keeps one page of eight words open after a read. A page is the set of words that share address bits 21..3. A later read into the open page changes only address bits 2..0 and waits the short in-page time instead of the full random-access time. A write, a read to another page, or a trip into sleep closes the page. Raising the power-down request puts the memory into deep sleep, which destroys its contents. Dropping the request wakes the memory. The controller then holds off the host for a programmable recovery count and raises a flag that tells the host the contents are lost.

Top module: `psram_page_ctrl`

## Requirements
- R1: After reset, chip-enable, output-enable, write-enable and both byte selects are high (inactive), the sleep select is high (awake), the data bus is not driven, rsp_valid and data_lost are low, and req_ready is high once reset is released.
- R2: A read to a closed page returns the addressed word on rsp_rdata with rsp_valid exactly MISS cycles after the accepting edge. MISS is the larger of ceil(T_ACC_PS/CLK_PS) and ceil(T_OE_PS/CLK_PS), and at least 2.
- R3: A read whose address bits 21..3 equal those of the open page returns its word exactly HIT = max(2, ceil(T_PAGE_PS/CLK_PS)) cycles after the accepting edge.
- R4: A write, a read to a different page, or entry into sleep closes the page, so the next read takes MISS cycles.
- R5: A write holds chip-enable low and pulses write-enable low for exactly WP = ceil(T_WP_PS/CLK_PS) cycles, one cycle after acceptance. Only the lanes whose req_be bit is 1 are written: bit 0 selects data bits 7..0 (mem_bsel_n[0]) and bit 1 selects bits 15..8 (mem_bsel_n[1]). The host port is ready again WP+1 cycles after the accepting edge.
- R6: The data bus is driven only while write-enable is low. It is never driven while output-enable is low, and it has been released for at least one full cycle whenever output-enable falls.
- R7: On a read, rsp_rdata lanes whose req_be bit is 0 read as zero.
- R8: req_ready is low from the accepting edge until the access completes, and while write-enable is low.
- R9: While pd_req is high and the controller is idle or asleep, the sleep select is low, chip-enable is high and req_ready is low.
- R10: When pd_req falls during sleep, the sleep select returns high, data_lost rises at the same edge, and req_ready stays low for exactly WAKE_CYC cycles. data_lost clears at the next accepted request.
- R11: rsp_valid is a single-cycle pulse, one per read and none for a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Controller accepts a request on this edge |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 22 | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte-lane enables, bit 1 = upper byte |
| rsp_valid | output | 1 | Read data valid pulse |
| rsp_rdata | output | 16 | Read data, disabled lanes zero |
| pd_req | input | 1 | Level request for deep sleep |
| data_lost | output | 1 | Memory contents lost after wake |
| mem_addr | output | 22 | Memory word address |
| mem_ce_n | output | 1 | Chip-enable, active low |
| mem_oe_n | output | 1 | Output-enable, active low |
| mem_we_n | output | 1 | Write-enable, active low |
| mem_bsel_n | output | 2 | Byte-lane selects, active low, bit 1 = upper |
| mem_sleep_n | output | 1 | Deep-sleep select, low = sleep |
| mem_dq_o | output | 16 | Data bus output value |
| mem_dq_oe | output | 1 | Data bus output enable |
| mem_dq_i | input | 16 | Data bus input value |

## Verification
The bench builds the controller with an 8 ns clock, a 75 ns random access, a 30 ns in-page access, a 25 ns output-enable delay, a 50 ns write pulse and a recovery count of 12. This gives waits of 10, 4 and 7 cycles. At these values one extra or one missing wait cycle shows up in the measured latency. A memory model in the bench returns garbage whenever address, chip-enable or output-enable timing has not been met, so a shortened hit or miss wait corrupts the returned data. The 12-cycle recovery makes the sleep and wake sequence short enough to run in full, followed by a read that must pay the miss time.

// File: rtl/psram_page_pkg.sv
`timescale 1ns/100ps
package psram_page_pkg;

  typedef enum logic [2:0] {
    PG_IDLE,
    PG_READ,
    PG_WSETUP,
    PG_WRITE,
    PG_SLEEP,
    PG_WAKE
  } pg_state_e;

  // whole clock cycles covering a time in picoseconds
  function automatic int unsigned cycles_for(input int unsigned t_ps, input int unsigned clk_ps);
    return (t_ps + clk_ps - 1) / clk_ps;
  endfunction

  function automatic int unsigned at_least(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/pgc_rst_sync.sv
`timescale 1ns/100ps
module pgc_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= 2'b00;
    else           sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_out = sync_q[1];
endmodule

// File: rtl/pgc_wait_timer.sv
`timescale 1ns/100ps
module pgc_wait_timer #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             done
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)              cnt_d = load_val;
    else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign done = (cnt_q == '0);
endmodule

// File: rtl/pgc_page_tag.sv
`timescale 1ns/100ps
module pgc_page_tag #(
  parameter int unsigned TAG_W = 19
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             open_en,
  input  logic             close_en,
  input  logic [TAG_W-1:0] tag_in,
  output logic             hit,
  output logic             is_open
);
  logic [TAG_W-1:0] tag_q, tag_d;
  logic             open_q, open_d;

  always_comb begin
    tag_d  = tag_q;
    open_d = open_q;
    if (close_en) begin
      open_d = 1'b0;
    end else if (open_en) begin
      open_d = 1'b1;
      tag_d  = tag_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tag_q  <= '0;
      open_q <= 1'b0;
    end else begin
      tag_q  <= tag_d;
      open_q <= open_d;
    end
  end

  assign hit     = open_q && (tag_in == tag_q);
  assign is_open = open_q;
endmodule

// File: rtl/psram_page_ctrl.sv
`timescale 1ns/100ps
module psram_page_ctrl
  import psram_page_pkg::*;
#(
  parameter int unsigned ADDR_W    = 22,
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned PAGE_BITS = 3,
  parameter int unsigned CLK_PS    = 8000,
  parameter int unsigned T_ACC_PS  = 75000,
  parameter int unsigned T_PAGE_PS = 30000,
  parameter int unsigned T_OE_PS   = 25000,
  parameter int unsigned T_WP_PS   = 50000,
  parameter int unsigned WAKE_CYC  = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_write,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [DATA_W-1:0]   req_wdata,
  input  logic [DATA_W/8-1:0] req_be,
  output logic                rsp_valid,
  output logic [DATA_W-1:0]   rsp_rdata,
  input  logic                pd_req,
  output logic                data_lost,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic                mem_ce_n,
  output logic                mem_oe_n,
  output logic                mem_we_n,
  output logic [DATA_W/8-1:0] mem_bsel_n,
  output logic                mem_sleep_n,
  output logic [DATA_W-1:0]   mem_dq_o,
  output logic                mem_dq_oe,
  input  logic [DATA_W-1:0]   mem_dq_i
);
  localparam int unsigned LANES    = DATA_W / 8;
  localparam int unsigned TAG_W    = ADDR_W - PAGE_BITS;
  localparam int unsigned MISS_CYC = at_least(at_least(cycles_for(T_ACC_PS, CLK_PS),
                                                       cycles_for(T_OE_PS, CLK_PS)), 2);
  localparam int unsigned HIT_CYC  = at_least(cycles_for(T_PAGE_PS, CLK_PS), 2);
  localparam int unsigned WP_CYC   = at_least(cycles_for(T_WP_PS, CLK_PS), 1);
  localparam int unsigned MAX_CYC  = at_least(at_least(MISS_CYC, WP_CYC), at_least(WAKE_CYC, 1));
  localparam int unsigned CNT_W    = $clog2(MAX_CYC + 1);

  logic                rst_sync_n;
  pg_state_e           state_q, state_d;
  logic [ADDR_W-1:0]   addr_q, addr_d;
  logic [DATA_W-1:0]   wdata_q, wdata_d;
  logic [LANES-1:0]    be_q, be_d;
  logic [DATA_W-1:0]   rdata_q, rdata_d;
  logic                rsp_q, rsp_d;
  logic                lost_q, lost_d;
  logic                tmr_load, tmr_done;
  logic [CNT_W-1:0]    tmr_val;
  logic                pg_open, pg_close, pg_hit, pg_is_open;
  logic [DATA_W-1:0]   lane_mask;

  pgc_rst_sync u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_sync_n)
  );

  pgc_wait_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .done     (tmr_done)
  );

  pgc_page_tag #(.TAG_W(TAG_W)) u_page (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .open_en  (pg_open),
    .close_en (pg_close),
    .tag_in   (req_addr[ADDR_W-1:PAGE_BITS]),
    .hit      (pg_hit),
    .is_open  (pg_is_open)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_mask[g*8 +: 8] = {8{be_q[g]}};
  end

  assign req_ready = (state_q == PG_IDLE) && !pd_req;

  // next state
  always_comb begin
    state_d  = state_q;
    addr_d   = addr_q;
    wdata_d  = wdata_q;
    be_d     = be_q;
    rdata_d  = rdata_q;
    rsp_d    = 1'b0;
    lost_d   = lost_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    pg_open  = 1'b0;
    pg_close = 1'b0;
    unique case (state_q)
      PG_IDLE: begin
        if (pd_req) begin
          state_d  = PG_SLEEP;
          pg_close = 1'b1;
        end else if (req_valid) begin
          addr_d = req_addr;
          be_d   = req_be;
          lost_d = 1'b0;
          if (req_write) begin
            state_d  = PG_WSETUP;
            wdata_d  = req_wdata;
            pg_close = 1'b1;
          end else begin
            state_d  = PG_READ;
            pg_open  = 1'b1;
            tmr_load = 1'b1;
            tmr_val  = pg_hit ? CNT_W'(HIT_CYC - 1) : CNT_W'(MISS_CYC - 1);
          end
        end
      end
      PG_READ: begin
        if (tmr_done) begin
          state_d = PG_IDLE;
          rsp_d   = 1'b1;
          rdata_d = mem_dq_i & lane_mask;
        end
      end
      PG_WSETUP: begin
        state_d  = PG_WRITE;
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(WP_CYC - 1);
      end
      PG_WRITE: begin
        if (tmr_done) state_d = PG_IDLE;
      end
      PG_SLEEP: begin
        if (!pd_req) begin
          state_d  = PG_WAKE;
          lost_d   = 1'b1;
          tmr_load = 1'b1;
          tmr_val  = CNT_W'(WAKE_CYC - 1);
        end
      end
      PG_WAKE: begin
        if (tmr_done) state_d = PG_IDLE;
      end
      default: state_d = PG_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q <= PG_IDLE;
      addr_q  <= '0;
      wdata_q <= '0;
      be_q    <= '0;
      rdata_q <= '0;
      rsp_q   <= 1'b0;
      lost_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      addr_q  <= addr_d;
      wdata_q <= wdata_d;
      be_q    <= be_d;
      rdata_q <= rdata_d;
      rsp_q   <= rsp_d;
      lost_q  <= lost_d;
    end
  end

  // memory pin decode
  always_comb begin
    mem_ce_n    = 1'b1;
    mem_oe_n    = 1'b1;
    mem_we_n    = 1'b1;
    mem_bsel_n  = '1;
    mem_sleep_n = 1'b1;
    mem_dq_oe   = 1'b0;
    unique case (state_q)
      PG_IDLE: begin
        if (pg_is_open) begin
          mem_ce_n   = 1'b0;
          mem_oe_n   = 1'b0;
          mem_bsel_n = ~be_q;
        end
      end
      PG_READ: begin
        mem_ce_n   = 1'b0;
        mem_oe_n   = 1'b0;
        mem_bsel_n = ~be_q;
      end
      PG_WSETUP: begin
        mem_ce_n   = 1'b0;
        mem_bsel_n = ~be_q;
      end
      PG_WRITE: begin
        mem_ce_n   = 1'b0;
        mem_we_n   = 1'b0;
        mem_dq_oe  = 1'b1;
        mem_bsel_n = ~be_q;
      end
      PG_SLEEP: mem_sleep_n = 1'b0;
      default: ;
    endcase
  end

  assign mem_addr  = addr_q;
  assign mem_dq_o  = wdata_q;
  assign rsp_valid = rsp_q;
  assign rsp_rdata = rdata_q;
  assign data_lost = lost_q;
endmodule

// File: rtl/psram_page_ctrl_chk.sv
`timescale 1ns/100ps
module psram_page_ctrl_chk
  import psram_page_pkg::*;
#(
  parameter int unsigned CLK_PS  = 8000,
  parameter int unsigned T_WP_PS = 50000
) (
  input logic clk,
  input logic rst_n,
  input logic req_ready,
  input logic rsp_valid,
  input logic data_lost,
  input logic mem_ce_n,
  input logic mem_oe_n,
  input logic mem_we_n,
  input logic mem_sleep_n,
  input logic mem_dq_oe
);
  localparam int unsigned WP_CYC = at_least(cycles_for(T_WP_PS, CLK_PS), 1);
  localparam int unsigned CW     = $clog2(WP_CYC + 2);

  logic [CW-1:0] we_low_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         we_low_cnt <= '0;
    else if (!mem_we_n) we_low_cnt <= we_low_cnt + 1'b1;
    else                we_low_cnt <= '0;
  end

  // R5
  we_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (we_low_cnt == CW'(WP_CYC)));

  // R5
  we_under_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> !mem_ce_n);

  // R6
  no_contention_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> (mem_oe_n && !mem_we_n));

  // R6
  release_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_oe_n) |-> !$past(mem_dq_oe));

  // R8
  busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> !req_ready);

  // R9
  sleep_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_sleep_n |-> (mem_ce_n && !req_ready));

  // R10
  wake_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_sleep_n) |-> data_lost);

  // R11
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
endmodule

bind psram_page_ctrl psram_page_ctrl_chk #(
  .CLK_PS  (CLK_PS),
  .T_WP_PS (T_WP_PS)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_ready   (req_ready),
  .rsp_valid   (rsp_valid),
  .data_lost   (data_lost),
  .mem_ce_n    (mem_ce_n),
  .mem_oe_n    (mem_oe_n),
  .mem_we_n    (mem_we_n),
  .mem_sleep_n (mem_sleep_n),
  .mem_dq_oe   (mem_dq_oe)
);

// File: tb/psram_page_ctrl_test.sv
`timescale 1ns/100ps
module psram_page_ctrl_test;
  localparam int CLK_PS  = 8000;
  localparam int WAKE    = 12;
  localparam int ACC_C   = (75000 + CLK_PS - 1) / CLK_PS;
  localparam int OE_C    = (25000 + CLK_PS - 1) / CLK_PS;
  localparam int MISS    = (ACC_C > OE_C) ? ACC_C : OE_C;
  localparam int HIT     = (30000 + CLK_PS - 1) / CLK_PS;
  localparam int WP      = (50000 + CLK_PS - 1) / CLK_PS;

  logic        clk, rst_n;
  logic        req_valid, req_ready, req_write;
  logic [21:0] req_addr;
  logic [15:0] req_wdata;
  logic [1:0]  req_be;
  logic        rsp_valid, pd_req, data_lost;
  logic [15:0] rsp_rdata;
  logic [21:0] mem_addr;
  logic        mem_ce_n, mem_oe_n, mem_we_n, mem_sleep_n, mem_dq_oe;
  logic [1:0]  mem_bsel_n;
  logic [15:0] mem_dq_o, mem_dq_i;

  int n_chk, n_bad, n_reads, n_rsp;

  psram_page_ctrl #(
    .CLK_PS    (CLK_PS),
    .T_ACC_PS  (75000),
    .T_PAGE_PS (30000),
    .T_OE_PS   (25000),
    .T_WP_PS   (50000),
    .WAKE_CYC  (WAKE)
  ) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .pd_req(pd_req), .data_lost(data_lost),
    .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_bsel_n(mem_bsel_n), .mem_sleep_n(mem_sleep_n), .mem_dq_o(mem_dq_o),
    .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
  );

  initial begin
    clk = 1'b0;
    forever #4 clk = ~clk;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // memory model: stale timing gives garbage
  logic [15:0] mem [0:255];
  real         t_full, t_any, t_oe, now;
  logic [21:0] m_addr;
  logic        m_ce_n, m_oe_n, m_we_n, ok;
  logic [7:0]  p_idx;
  logic [15:0] p_data;
  logic [1:0]  p_bsel_n;

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = {8'(i) ^ 8'hA5, 8'(i)};
    t_full = 0.0; t_any = 0.0; t_oe = 0.0;
    m_we_n = 1'b1;
    mem_dq_i = 16'hDEAD;
    #0.5;
    forever begin
      now = $realtime;
      if (mem_addr !== m_addr) begin
        if (mem_addr[21:3] !== m_addr[21:3]) t_full = now - 0.5;
        t_any  = now - 0.5;
        m_addr = mem_addr;
      end
      if (mem_ce_n === 1'b0 && m_ce_n !== 1'b0) t_full = now - 0.5;
      if (mem_oe_n === 1'b0 && m_oe_n !== 1'b0) t_oe = now - 0.5;
      m_ce_n = mem_ce_n;
      m_oe_n = mem_oe_n;
      if (mem_we_n === 1'b0 && mem_ce_n === 1'b0) begin
        p_idx = mem_addr[7:0]; p_data = mem_dq_o; p_bsel_n = mem_bsel_n;
      end
      if (mem_we_n === 1'b1 && m_we_n === 1'b0) begin
        if (!p_bsel_n[0]) mem[p_idx][7:0]  = p_data[7:0];
        if (!p_bsel_n[1]) mem[p_idx][15:8] = p_data[15:8];
      end
      m_we_n = mem_we_n;
      if (mem_sleep_n === 1'b0)
        for (int i = 0; i < 256; i++) mem[i] = 16'h5A5A;
      ok = (mem_ce_n === 1'b0) && (mem_oe_n === 1'b0) && (mem_sleep_n === 1'b1) &&
           (now - t_full >= 75.0) && (now - t_any >= 30.0) && (now - t_oe >= 25.0);
      if (ok)
        mem_dq_i = {mem_bsel_n[1] ? 8'hEE : mem[mem_addr[7:0]][15:8],
                    mem_bsel_n[0] ? 8'hEE : mem[mem_addr[7:0]][7:0]};
      else
        mem_dq_i = 16'hDEAD;
      #1;
    end
  end

  // bus monitor
  logic prev_oe_n, prev_dq_oe;
  int   we_low;
  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_dq_oe && !mem_oe_n) chk("R6 bus driven with OE low", 1, 0);
      if (mem_dq_oe && mem_we_n)  chk("R6 bus driven with WE high", 1, 0);
      if (prev_oe_n && !mem_oe_n) chk("R6 bus released before OE falls", 32'(prev_dq_oe), 0);
      if (!mem_we_n) we_low++;
      else if (we_low != 0) begin
        chk("R5 write pulse width", we_low, WP);
        we_low = 0;
      end
      if (rsp_valid) n_rsp++;
    end
    prev_oe_n  = mem_oe_n;
    prev_dq_oe = mem_dq_oe;
  end

  task automatic do_req(input logic wr, input logic [1:0] be, input logic [21:0] addr,
                        input logic [15:0] wd, output int lat, output logic [15:0] data,
                        output logic busy_ok);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_be = be; req_addr = addr; req_wdata = wd;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    #1 req_valid = 1'b0;
    lat = 0; data = '0; busy_ok = 1'b1;
    forever begin
      @(negedge clk);
      if (lat == 0) busy_ok = !req_ready;
      if (wr ? req_ready : rsp_valid) begin
        data = rsp_rdata;
        break;
      end
      lat++;
    end
    if (!wr) n_reads++;
  endtask

  // {write, be, addr, wdata, expected read, page hit}
  localparam logic [57:0] VEC [0:11] = '{
    {1'b1, 2'b11, 22'h000010, 16'h1234, 16'h0000, 1'b0},
    {1'b1, 2'b01, 22'h000011, 16'hABCD, 16'h0000, 1'b0},
    {1'b1, 2'b10, 22'h000012, 16'h5678, 16'h0000, 1'b0},
    {1'b0, 2'b11, 22'h000010, 16'h0000, 16'h1234, 1'b0},
    {1'b0, 2'b11, 22'h000011, 16'h0000, 16'hB4CD, 1'b1},
    {1'b0, 2'b01, 22'h000012, 16'h0000, 16'h0012, 1'b1},
    {1'b0, 2'b10, 22'h000017, 16'h0000, 16'hB200, 1'b1},
    {1'b0, 2'b11, 22'h3FFF20, 16'h0000, 16'h8520, 1'b0},
    {1'b0, 2'b11, 22'h3FFF27, 16'h0000, 16'h8227, 1'b1},
    {1'b1, 2'b11, 22'h000030, 16'hFFFF, 16'h0000, 1'b0},
    {1'b0, 2'b11, 22'h3FFF21, 16'h0000, 16'h8421, 1'b0},
    {1'b0, 2'b11, 22'h000030, 16'h0000, 16'hFFFF, 1'b0}
  };

  initial begin
    int          lat;
    logic [15:0] data;
    logic        busy_ok;
    logic [57:0] v;
    n_chk = 0; n_bad = 0; n_reads = 0; n_rsp = 0; we_low = 0;
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0;
    req_wdata = '0; req_be = '0; pd_req = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 pins after reset", {mem_ce_n, mem_oe_n, mem_we_n, mem_bsel_n, mem_sleep_n, mem_dq_oe},
        7'b1111110);
    chk("R1 flags after reset", {req_ready, rsp_valid, data_lost}, 3'b100);

    for (int i = 0; i < 12; i++) begin
      v = VEC[i];
      do_req(v[57], v[56:55], v[54:33], v[32:17], lat, data, busy_ok);
      chk("R8 ready low after accept", 32'(busy_ok), 1);
      if (v[57]) begin
        chk("R5 write occupancy", lat, WP + 1);
      end else begin
        if (v[0])                 chk("R3 page hit latency", lat, HIT);
        else if (i == 7 || i == 10) chk("R4 page closed, miss latency", lat, MISS);
        else                      chk("R2 miss latency", lat, MISS);
        if (v[56:55] != 2'b11)    chk("R7 masked read data", data, v[16:1]);
        else                      chk("R2 read data", data, v[16:1]);
      end
    end

    // deep sleep and wake
    @(negedge clk); pd_req = 1'b1;
    @(negedge clk);
    chk("R9 sleep entry pins", {mem_sleep_n, mem_ce_n, req_ready}, 3'b010);
    repeat (4) @(negedge clk);
    chk("R9 sleep held", {mem_sleep_n, req_ready}, 2'b00);
    pd_req = 1'b0;
    lat = 0;
    forever begin
      @(negedge clk);
      if (lat == 0) chk("R10 wake pins and flag", {mem_sleep_n, data_lost, req_ready}, 3'b110);
      if (req_ready) break;
      lat++;
    end
    chk("R10 recovery length", lat, WAKE);
    chk("R10 flag held to first request", 32'(data_lost), 1);
    do_req(1'b0, 2'b11, 22'h000030, 16'h0000, lat, data, busy_ok);
    chk("R4 miss after sleep", lat, MISS);
    chk("R10 contents lost after sleep", data, 16'h5A5A);
    chk("R10 flag cleared by request", 32'(data_lost), 0);
    repeat (3) @(negedge clk);
    chk("R11 one pulse per read", n_rsp, n_reads);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule